// File: doc/BRIEF.md
# Ingress Virtual Channel Mapper

This block sits where a master's AXI write-address and read-address requests enter a network-on-chip access point. Each accepted request leaves with a header. The header holds three things: the virtual channel the request travels on, the virtual channel its response must come back on, and a QoS value. The QoS value is the request's own 4-bit AXI QoS when carrying is enabled, and zero when it is not. A physical link has eight virtual channels, so each channel number is 3 bits wide.

A single configuration register holds the channel pair and the QoS enable. The block counts outstanding writes and reads. A transaction is counted when its request is accepted. It is released on its B response, or on the R beat that carries the last flag.

Software raises a quiesce request to change the mapping. The block then stops accepting new requests. It acknowledges once no transaction is in flight. A register write is taken only while that acknowledge is high, and only when the two channels differ. Any other write is dropped and sets a sticky error flag.

Top module: `vc_ingress_mapper`

## Requirements
- R1: After reset the request channel reads 0, the response channel reads 1, QoS carrying is off, and both the error flag and the quiesce acknowledge are low.
- R2: When not blocked, the request valid and ready signals pass through in the same cycle. The address passes unchanged. The header request-channel and response-channel fields equal the current register values.
- R3: The header QoS field equals the request's AXI QoS while the enable bit is 1. It is 0 while the enable bit is 0.
- R4: A write counter rises on each accepted write request and falls on a B handshake. A read counter rises on each accepted read request and falls on an R handshake with last set. An R beat without last does not change the read counter. A response that arrives with its counter at zero leaves the counter at zero. A channel whose counter has reached MAX_OUTST stops accepting requests.
- R5: While the quiesce request is high, both request channels show ready low and outgoing valid low in the same cycle.
- R6: The acknowledge goes high one cycle after a clock edge at which the quiesce request is high and both counters are zero. It goes low one cycle after the request is withdrawn.
- R7: A register write made while the acknowledge is high, with different channel values, takes effect at that clock edge.
- R8: A register write made while the acknowledge is low leaves all fields unchanged and sets the sticky error flag.
- R9: A register write with equal request and response channels leaves all fields unchanged and sets the sticky error flag, even while the acknowledge is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Mapping register write strobe |
| cfg_wr_req_vc | input | 3 | New request channel |
| cfg_wr_rsp_vc | input | 3 | New response channel |
| cfg_wr_qos_en | input | 1 | New QoS carry enable |
| cfg_req_vc | output | 3 | Current request channel |
| cfg_rsp_vc | output | 3 | Current response channel |
| cfg_qos_en | output | 1 | Current QoS carry enable |
| cfg_err | output | 1 | Sticky rejected-write flag |
| quiesce_req | input | 1 | Request to drain the port |
| quiesce_ack | output | 1 | Port drained and blocked |
| s_awvalid | input | 1 | Write request valid from master |
| s_awready | output | 1 | Write request ready to master |
| s_awaddr | input | ADDR_W | Write address |
| s_awqos | input | 4 | Write AXI QoS |
| m_awvalid | output | 1 | Tagged write request valid |
| m_awready | input | 1 | Tagged write request ready |
| m_awaddr | output | ADDR_W | Tagged write address |
| m_aw_vc | output | 3 | Write header request channel |
| m_aw_rsp_vc | output | 3 | Write header response channel |
| m_aw_qos | output | 4 | Write header QoS |
| s_arvalid | input | 1 | Read request valid from master |
| s_arready | output | 1 | Read request ready to master |
| s_araddr | input | ADDR_W | Read address |
| s_arqos | input | 4 | Read AXI QoS |
| m_arvalid | output | 1 | Tagged read request valid |
| m_arready | input | 1 | Tagged read request ready |
| m_araddr | output | ADDR_W | Tagged read address |
| m_ar_vc | output | 3 | Read header request channel |
| m_ar_rsp_vc | output | 3 | Read header response channel |
| m_ar_qos | output | 4 | Read header QoS |
| rsp_bvalid | input | 1 | Observed B valid |
| rsp_bready | input | 1 | Observed B ready |
| rsp_rvalid | input | 1 | Observed R valid |
| rsp_rready | input | 1 | Observed R ready |
| rsp_rlast | input | 1 | Observed R last flag |

## Verification
The block's outputs fall due at two different times. The header fields and the request handshake, including blocking by quiesce or by a full counter, are combinational, so they are due in the same cycle as the stimulus. Counter updates, register writes and the error flag take effect at the next clock edge. The acknowledge sits one register further on from the counters, so it is due one edge after the drain completes. The bench drives inputs just after a falling edge. It checks combinational results one nanosecond later, and registered results after the next falling edge, by which time exactly one rising edge has passed.

// File: rtl/vcm_pkg.sv
package vcm_pkg;
   localparam int NUM_VC = 8;
   localparam int VC_W   = $clog2(NUM_VC);
   localparam int QOS_W  = 4;
   localparam int NUM_CH = 2;
   localparam int CH_WR  = 0;
   localparam int CH_RD  = 1;

   typedef logic [VC_W-1:0]  vc_t;
   typedef logic [QOS_W-1:0] qos_t;

   typedef struct packed {
      vc_t  req_vc;
      vc_t  rsp_vc;
      qos_t qos;
   } hdr_t;
endpackage

// File: rtl/vcm_map_regs.sv
module vcm_map_regs
   import vcm_pkg::*;
#(
   parameter int unsigned DEF_REQ_VC = 0,
   parameter int unsigned DEF_RSP_VC = 1,
   parameter bit          DEF_QOS_EN = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic wr,
   input  vc_t  wr_req_vc,
   input  vc_t  wr_rsp_vc,
   input  logic wr_qos_en,
   input  logic quiesced,
   output vc_t  req_vc,
   output vc_t  rsp_vc,
   output logic qos_en,
   output logic err
);
   localparam vc_t RST_REQ = vc_t'(DEF_REQ_VC);
   localparam vc_t RST_RSP = vc_t'(DEF_RSP_VC);

   if (DEF_REQ_VC >= NUM_VC || DEF_RSP_VC >= NUM_VC) begin : g_bad_range
      $error("vcm_map_regs: default channel out of range");
   end
   if (DEF_REQ_VC == DEF_RSP_VC) begin : g_bad_equal
      $error("vcm_map_regs: default request and response channels must differ");
   end

   logic take;
   assign take = wr && quiesced && (wr_req_vc != wr_rsp_vc);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         req_vc <= RST_REQ;
         rsp_vc <= RST_RSP;
         qos_en <= DEF_QOS_EN;
         err    <= 1'b0;
      end else if (take) begin
         req_vc <= wr_req_vc;
         rsp_vc <= wr_rsp_vc;
         qos_en <= wr_qos_en;
      end else if (wr) begin
         err <= 1'b1;
      end
   end

   // R9: the two channels never coincide
   a_r9_distinct_vc: assert property (@(posedge clk) disable iff (!rst_n)
      req_vc != rsp_vc);

   // R7/R8: a mapping change always follows an acknowledged quiesce
   a_r8_change_only_quiesced: assert property (@(posedge clk) disable iff (!rst_n)
      (!$stable(req_vc) || !$stable(rsp_vc) || !$stable(qos_en)) |-> $past(quiesced));

   // R8/R9: error flag is sticky
   a_r8_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      $past(err) |-> err);
endmodule

// File: rtl/vcm_outst_cnt.sv
module vcm_outst_cnt #(
   parameter int unsigned MAX_OUTST = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic inc,
   input  logic dec,
   output logic full,
   output logic empty
);
   localparam int CNT_W = $clog2(MAX_OUTST + 1);
   localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(MAX_OUTST);

   if (MAX_OUTST < 1) begin : g_bad_max
      $error("vcm_outst_cnt: MAX_OUTST must be at least 1");
   end

   logic [CNT_W-1:0] cnt_q;
   logic             dec_ok;

   assign empty  = (cnt_q == '0);
   assign full   = (cnt_q == CNT_MAX);
   assign dec_ok = dec && !empty;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else begin
         unique case ({inc, dec_ok})
            2'b10:   cnt_q <= cnt_q + 1'b1;
            2'b01:   cnt_q <= cnt_q - 1'b1;
            default: cnt_q <= cnt_q;
         endcase
      end
   end

   // R4: acceptance never happens with the counter at its limit
   a_r4_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
      full |-> !inc);

   // R4: counter stays within range
   a_r4_in_range: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= CNT_MAX);
endmodule

// File: rtl/vcm_hdr_tag.sv
module vcm_hdr_tag
   import vcm_pkg::*;
#(
   parameter bit QOS_CARRY = 1'b1
) (
   input  logic blk,
   input  logic s_valid,
   output logic s_ready,
   input  qos_t s_qos,
   output logic m_valid,
   input  logic m_ready,
   input  vc_t  req_vc,
   input  vc_t  rsp_vc,
   input  logic qos_en,
   output hdr_t hdr,
   output logic accept
);
   assign m_valid = s_valid && !blk;
   assign s_ready = m_ready && !blk;
   assign accept  = s_valid && s_ready;

   assign hdr.req_vc = req_vc;
   assign hdr.rsp_vc = rsp_vc;

   if (QOS_CARRY) begin : g_qos_carry
      assign hdr.qos = qos_en ? s_qos : '0;
   end else begin : g_qos_none
      logic unused_qos;
      assign unused_qos = qos_en ^ (^s_qos);
      assign hdr.qos    = '0;
   end
endmodule

// File: rtl/vc_ingress_mapper.sv
module vc_ingress_mapper
   import vcm_pkg::*;
#(
   parameter int unsigned ADDR_W     = 64,
   parameter int unsigned MAX_OUTST  = 16,
   parameter int unsigned DEF_REQ_VC = 0,
   parameter int unsigned DEF_RSP_VC = 1,
   parameter bit          DEF_QOS_EN = 1'b0,
   parameter bit          QOS_CARRY  = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_wr,
   input  logic [2:0]        cfg_wr_req_vc,
   input  logic [2:0]        cfg_wr_rsp_vc,
   input  logic              cfg_wr_qos_en,
   output logic [2:0]        cfg_req_vc,
   output logic [2:0]        cfg_rsp_vc,
   output logic              cfg_qos_en,
   output logic              cfg_err,
   input  logic              quiesce_req,
   output logic              quiesce_ack,
   input  logic              s_awvalid,
   output logic              s_awready,
   input  logic [ADDR_W-1:0] s_awaddr,
   input  logic [3:0]        s_awqos,
   output logic              m_awvalid,
   input  logic              m_awready,
   output logic [ADDR_W-1:0] m_awaddr,
   output logic [2:0]        m_aw_vc,
   output logic [2:0]        m_aw_rsp_vc,
   output logic [3:0]        m_aw_qos,
   input  logic              s_arvalid,
   output logic              s_arready,
   input  logic [ADDR_W-1:0] s_araddr,
   input  logic [3:0]        s_arqos,
   output logic              m_arvalid,
   input  logic              m_arready,
   output logic [ADDR_W-1:0] m_araddr,
   output logic [2:0]        m_ar_vc,
   output logic [2:0]        m_ar_rsp_vc,
   output logic [3:0]        m_ar_qos,
   input  logic              rsp_bvalid,
   input  logic              rsp_bready,
   input  logic              rsp_rvalid,
   input  logic              rsp_rready,
   input  logic              rsp_rlast
);
   if (ADDR_W < 1) begin : g_bad_addr
      $error("vc_ingress_mapper: ADDR_W must be positive");
   end

   vc_t  req_vc, rsp_vc;
   logic qos_en;
   logic ack_q;

   vcm_map_regs #(
      .DEF_REQ_VC (DEF_REQ_VC),
      .DEF_RSP_VC (DEF_RSP_VC),
      .DEF_QOS_EN (DEF_QOS_EN)
   ) i_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr        (cfg_wr),
      .wr_req_vc (cfg_wr_req_vc),
      .wr_rsp_vc (cfg_wr_rsp_vc),
      .wr_qos_en (cfg_wr_qos_en),
      .quiesced  (ack_q),
      .req_vc    (req_vc),
      .rsp_vc    (rsp_vc),
      .qos_en    (qos_en),
      .err       (cfg_err)
   );

   logic [NUM_CH-1:0] ch_svalid, ch_sready, ch_mvalid, ch_mready;
   logic [NUM_CH-1:0] ch_blk, ch_accept, ch_done, ch_full, ch_empty;
   qos_t              ch_qos [NUM_CH];
   hdr_t              ch_hdr [NUM_CH];

   assign ch_svalid[CH_WR] = s_awvalid;
   assign ch_svalid[CH_RD] = s_arvalid;
   assign ch_mready[CH_WR] = m_awready;
   assign ch_mready[CH_RD] = m_arready;
   assign ch_qos[CH_WR]    = s_awqos;
   assign ch_qos[CH_RD]    = s_arqos;
   assign ch_done[CH_WR]   = rsp_bvalid && rsp_bready;
   assign ch_done[CH_RD]   = rsp_rvalid && rsp_rready && rsp_rlast;

   for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      assign ch_blk[c] = quiesce_req || ch_full[c];

      vcm_hdr_tag #(
         .QOS_CARRY (QOS_CARRY)
      ) i_tag (
         .blk     (ch_blk[c]),
         .s_valid (ch_svalid[c]),
         .s_ready (ch_sready[c]),
         .s_qos   (ch_qos[c]),
         .m_valid (ch_mvalid[c]),
         .m_ready (ch_mready[c]),
         .req_vc  (req_vc),
         .rsp_vc  (rsp_vc),
         .qos_en  (qos_en),
         .hdr     (ch_hdr[c]),
         .accept  (ch_accept[c])
      );

      vcm_outst_cnt #(
         .MAX_OUTST (MAX_OUTST)
      ) i_cnt (
         .clk   (clk),
         .rst_n (rst_n),
         .inc   (ch_accept[c]),
         .dec   (ch_done[c]),
         .full  (ch_full[c]),
         .empty (ch_empty[c])
      );
   end

   always_ff @(posedge clk) begin
      if (!rst_n) ack_q <= 1'b0;
      else        ack_q <= quiesce_req && (&ch_empty);
   end

   assign quiesce_ack = ack_q;
   assign cfg_req_vc  = req_vc;
   assign cfg_rsp_vc  = rsp_vc;
   assign cfg_qos_en  = qos_en;

   assign s_awready   = ch_sready[CH_WR];
   assign m_awvalid   = ch_mvalid[CH_WR];
   assign m_awaddr    = s_awaddr;
   assign m_aw_vc     = ch_hdr[CH_WR].req_vc;
   assign m_aw_rsp_vc = ch_hdr[CH_WR].rsp_vc;
   assign m_aw_qos    = ch_hdr[CH_WR].qos;

   assign s_arready   = ch_sready[CH_RD];
   assign m_arvalid   = ch_mvalid[CH_RD];
   assign m_araddr    = s_araddr;
   assign m_ar_vc     = ch_hdr[CH_RD].req_vc;
   assign m_ar_rsp_vc = ch_hdr[CH_RD].rsp_vc;
   assign m_ar_qos    = ch_hdr[CH_RD].qos;

   // R5: quiesce closes both request channels
   a_r5_block_on_quiesce: assert property (@(posedge clk) disable iff (!rst_n)
      quiesce_req |-> (!s_awready && !s_arready && !m_awvalid && !m_arvalid));

   // R6: an acknowledged port has nothing in flight
   a_r6_ack_idle: assert property (@(posedge clk) disable iff (!rst_n)
      quiesce_ack |-> (&ch_empty));

   // R6: acknowledge only follows a held quiesce request
   a_r6_ack_follows_req: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(quiesce_ack) |-> $past(quiesce_req));

   // R3: QoS zeroed while carrying is off
   a_r3_qos_zero: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_qos_en |-> (m_aw_qos == '0 && m_ar_qos == '0));

   // R2: header keeps requests and responses on different channels
   a_r2_split_channels: assert property (@(posedge clk) disable iff (!rst_n)
      (m_aw_vc != m_aw_rsp_vc) && (m_ar_vc != m_ar_rsp_vc));
endmodule

// File: tb/test_vc_ingress_mapper.sv
module test_vc_ingress_mapper;
   localparam int AW  = 32;
   localparam int MAX = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cfg_wr = 1'b0;
   logic [2:0] cfg_wr_req_vc = '0, cfg_wr_rsp_vc = '0;
   logic cfg_wr_qos_en = 1'b0;
   logic [2:0] cfg_req_vc, cfg_rsp_vc;
   logic cfg_qos_en, cfg_err;
   logic quiesce_req = 1'b0;
   logic quiesce_ack;
   logic s_awvalid = 1'b0, s_arvalid = 1'b0;
   logic s_awready, s_arready;
   logic [AW-1:0] s_awaddr = '0, s_araddr = '0;
   logic [3:0] s_awqos = '0, s_arqos = '0;
   logic m_awvalid, m_arvalid;
   logic m_awready = 1'b0, m_arready = 1'b0;
   logic [AW-1:0] m_awaddr, m_araddr;
   logic [2:0] m_aw_vc, m_aw_rsp_vc, m_ar_vc, m_ar_rsp_vc;
   logic [3:0] m_aw_qos, m_ar_qos;
   logic rsp_bvalid = 1'b0, rsp_bready = 1'b0;
   logic rsp_rvalid = 1'b0, rsp_rready = 1'b0, rsp_rlast = 1'b0;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   vc_ingress_mapper #(.ADDR_W(AW), .MAX_OUTST(MAX)) i_vc_ingress_mapper (
      .clk(clk), .rst_n(rst_n),
      .cfg_wr(cfg_wr), .cfg_wr_req_vc(cfg_wr_req_vc), .cfg_wr_rsp_vc(cfg_wr_rsp_vc),
      .cfg_wr_qos_en(cfg_wr_qos_en), .cfg_req_vc(cfg_req_vc), .cfg_rsp_vc(cfg_rsp_vc),
      .cfg_qos_en(cfg_qos_en), .cfg_err(cfg_err),
      .quiesce_req(quiesce_req), .quiesce_ack(quiesce_ack),
      .s_awvalid(s_awvalid), .s_awready(s_awready), .s_awaddr(s_awaddr), .s_awqos(s_awqos),
      .m_awvalid(m_awvalid), .m_awready(m_awready), .m_awaddr(m_awaddr),
      .m_aw_vc(m_aw_vc), .m_aw_rsp_vc(m_aw_rsp_vc), .m_aw_qos(m_aw_qos),
      .s_arvalid(s_arvalid), .s_arready(s_arready), .s_araddr(s_araddr), .s_arqos(s_arqos),
      .m_arvalid(m_arvalid), .m_arready(m_arready), .m_araddr(m_araddr),
      .m_ar_vc(m_ar_vc), .m_ar_rsp_vc(m_ar_rsp_vc), .m_ar_qos(m_ar_qos),
      .rsp_bvalid(rsp_bvalid), .rsp_bready(rsp_bready),
      .rsp_rvalid(rsp_rvalid), .rsp_rready(rsp_rready), .rsp_rlast(rsp_rlast)
   );

   task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", what, act, exp);
      end
   endtask

   task automatic idle_inputs();
      cfg_wr = 1'b0; quiesce_req = 1'b0;
      s_awvalid = 1'b0; s_arvalid = 1'b0; m_awready = 1'b0; m_arready = 1'b0;
      rsp_bvalid = 1'b0; rsp_bready = 1'b0;
      rsp_rvalid = 1'b0; rsp_rready = 1'b0; rsp_rlast = 1'b0;
   endtask

   task automatic do_reset();
      @(negedge clk);
      idle_inputs();
      rst_n = 1'b0;
      @(negedge clk);
      @(negedge clk);
      rst_n = 1'b1;
   endtask

   // one accepted request per call on the selected channel (0 write, 1 read)
   task automatic send_req(input bit rd, input logic [3:0] qos);
      @(negedge clk);
      if (rd) begin s_arvalid = 1'b1; m_arready = 1'b1; s_arqos = qos; end
      else    begin s_awvalid = 1'b1; m_awready = 1'b1; s_awqos = qos; end
      @(negedge clk);
      s_awvalid = 1'b0; m_awready = 1'b0; s_arvalid = 1'b0; m_arready = 1'b0;
   endtask

   task automatic t_reset();
      do_reset();
      #1;
      chk("R1 req_vc", cfg_req_vc, 0);
      chk("R1 rsp_vc", cfg_rsp_vc, 1);
      chk("R1 qos_en", cfg_qos_en, 0);
      chk("R1 err", cfg_err, 0);
      chk("R1 ack", quiesce_ack, 0);
   endtask

   task automatic t_pass_and_drain();
      do_reset();
      @(negedge clk);
      s_awvalid = 1'b1; m_awready = 1'b1; s_awqos = 4'h5; s_awaddr = 32'hCAFE_0010;
      #1;
      chk("R2 m_awvalid", m_awvalid, 1);
      chk("R2 s_awready", s_awready, 1);
      chk("R2 m_awaddr", m_awaddr, 32'hCAFE_0010);
      chk("R2 m_aw_vc", m_aw_vc, 0);
      chk("R2 m_aw_rsp_vc", m_aw_rsp_vc, 1);
      chk("R3 qos off", m_aw_qos, 0);
      @(negedge clk);
      s_awvalid = 1'b0; m_awready = 1'b0;
      send_req(1'b1, 4'h2);
      // R5: quiesce blocks both channels at once
      @(negedge clk);
      quiesce_req = 1'b1;
      s_awvalid = 1'b1; m_awready = 1'b1; s_arvalid = 1'b1; m_arready = 1'b1;
      #1;
      chk("R5 s_awready", s_awready, 0);
      chk("R5 m_awvalid", m_awvalid, 0);
      chk("R5 s_arready", s_arready, 0);
      chk("R5 m_arvalid", m_arvalid, 0);
      @(negedge clk);
      s_awvalid = 1'b0; m_awready = 1'b0; s_arvalid = 1'b0; m_arready = 1'b0;
      @(negedge clk);
      chk("R6 ack waits for drain", quiesce_ack, 0);
      // R4: R beat without last does not release the read
      rsp_bvalid = 1'b1; rsp_bready = 1'b1;
      rsp_rvalid = 1'b1; rsp_rready = 1'b1; rsp_rlast = 1'b0;
      @(negedge clk);
      rsp_bvalid = 1'b0; rsp_bready = 1'b0;
      rsp_rvalid = 1'b0; rsp_rready = 1'b0;
      @(negedge clk);
      chk("R4 non-last beat keeps read outstanding", quiesce_ack, 0);
      rsp_rvalid = 1'b1; rsp_rready = 1'b1; rsp_rlast = 1'b1;
      @(negedge clk);
      rsp_rvalid = 1'b0; rsp_rready = 1'b0; rsp_rlast = 1'b0;
      chk("R6 ack one edge after drain", quiesce_ack, 0);
      @(negedge clk);
      chk("R6 ack raised", quiesce_ack, 1);
   endtask

   task automatic t_cfg_and_qos();
      // continues from a quiesced port
      cfg_wr = 1'b1; cfg_wr_req_vc = 3'd4; cfg_wr_rsp_vc = 3'd6; cfg_wr_qos_en = 1'b1;
      @(negedge clk);
      cfg_wr = 1'b0;
      chk("R7 req_vc", cfg_req_vc, 4);
      chk("R7 rsp_vc", cfg_rsp_vc, 6);
      chk("R7 qos_en", cfg_qos_en, 1);
      chk("R7 no err", cfg_err, 0);
      quiesce_req = 1'b0;
      @(negedge clk);
      chk("R6 ack dropped", quiesce_ack, 0);
      s_arvalid = 1'b1; m_arready = 1'b1; s_arqos = 4'h9;
      #1;
      chk("R3 qos carried", m_ar_qos, 9);
      chk("R2 m_ar_vc", m_ar_vc, 4);
      chk("R2 m_ar_rsp_vc", m_ar_rsp_vc, 6);
      @(negedge clk);
      s_arvalid = 1'b0; m_arready = 1'b0;
   endtask

   task automatic t_equal_rejected();
      do_reset();
      @(negedge clk);
      quiesce_req = 1'b1;
      @(negedge clk);
      chk("R6 ack on idle port", quiesce_ack, 1);
      cfg_wr = 1'b1; cfg_wr_req_vc = 3'd2; cfg_wr_rsp_vc = 3'd2; cfg_wr_qos_en = 1'b1;
      @(negedge clk);
      cfg_wr = 1'b0;
      chk("R9 req_vc kept", cfg_req_vc, 0);
      chk("R9 rsp_vc kept", cfg_rsp_vc, 1);
      chk("R9 qos_en kept", cfg_qos_en, 0);
      chk("R9 err set", cfg_err, 1);
   endtask

   task automatic t_not_quiesced();
      do_reset();
      @(negedge clk);
      cfg_wr = 1'b1; cfg_wr_req_vc = 3'd3; cfg_wr_rsp_vc = 3'd5; cfg_wr_qos_en = 1'b1;
      @(negedge clk);
      cfg_wr = 1'b0;
      chk("R8 req_vc kept", cfg_req_vc, 0);
      chk("R8 rsp_vc kept", cfg_rsp_vc, 1);
      chk("R8 qos_en kept", cfg_qos_en, 0);
      chk("R8 err set", cfg_err, 1);
      @(negedge clk);
      chk("R8 err sticky", cfg_err, 1);
   endtask

   task automatic t_full();
      do_reset();
      // spurious B with nothing outstanding must not disturb the counter
      @(negedge clk);
      rsp_bvalid = 1'b1; rsp_bready = 1'b1;
      @(negedge clk);
      rsp_bvalid = 1'b0; rsp_bready = 1'b0;
      for (int i = 0; i < MAX; i++) send_req(1'b0, 4'h0);
      @(negedge clk);
      s_awvalid = 1'b1; m_awready = 1'b1;
      #1;
      chk("R4 write stalls at limit", s_awready, 0);
      chk("R4 no valid at limit", m_awvalid, 0);
      s_awvalid = 1'b0; m_awready = 1'b0;
      rsp_bvalid = 1'b1; rsp_bready = 1'b1;
      @(negedge clk);
      rsp_bvalid = 1'b0; rsp_bready = 1'b0;
      s_awvalid = 1'b1; m_awready = 1'b1;
      #1;
      chk("R4 write resumes after B", s_awready, 1);
      @(negedge clk);
      s_awvalid = 1'b0; m_awready = 1'b0;
      for (int i = 0; i < MAX; i++) send_req(1'b1, 4'h0);
      @(negedge clk);
      s_arvalid = 1'b1; m_arready = 1'b1;
      #1;
      chk("R4 read stalls at limit", s_arready, 0);
      s_arvalid = 1'b0; m_arready = 1'b0;
      rsp_rvalid = 1'b1; rsp_rready = 1'b1; rsp_rlast = 1'b0;
      @(negedge clk);
      rsp_rvalid = 1'b0; rsp_rready = 1'b0;
      s_arvalid = 1'b1; m_arready = 1'b1;
      #1;
      chk("R4 read still stalled after non-last", s_arready, 0);
      s_arvalid = 1'b0; m_arready = 1'b0;
      rsp_rvalid = 1'b1; rsp_rready = 1'b1; rsp_rlast = 1'b1;
      @(negedge clk);
      rsp_rvalid = 1'b0; rsp_rready = 1'b0; rsp_rlast = 1'b0;
      s_arvalid = 1'b1; m_arready = 1'b1;
      #1;
      chk("R4 read resumes after last", s_arready, 1);
      @(negedge clk);
      s_arvalid = 1'b0; m_arready = 1'b0;
   endtask

   initial begin
      t_reset();
      t_pass_and_drain();
      t_cfg_and_qos();
      t_equal_rejected();
      t_not_quiesced();
      t_full();
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule